// File: doc/BRIEF.md
# Bus Write FIFO Status Timers

This block produces the status word of an expansion bus write queue without holding any of the queued data. Every bus write strobe feeds five countdown timers. The timers raise and drop three flags in the status word after fixed numbers of clock edges. A "busy" flag on bit 5 goes up on the write itself and drops once the queue would have drained. A "pending" flag on bit 4 rises after a short delay and falls after a longer one. A "done" flag on bit 0 follows the same rise-then-fall pattern, using its own two delays. The three positions are fixed, because the software that reads the word decodes them.

A timer that is still running when another write arrives is pushed later by one more delay instead of being restarted, so a run of back-to-back writes keeps the flags active for their summed drain time. A rise timer that is already running ignores new writes. A timer that has fired goes idle and does nothing until a later write arms it again. The remaining count of every timer is capped at the largest value its counter can hold. A read strobe copies the live status word into a read-data register.

Top module: `busfifo_stat_timers`

## Requirements
- R1: While reset is asserted, and after reset until the first write, `status_o` and `rd_data_o` are zero.
- R2: A write strobe sampled at a clock edge sets status bit 5 on that edge.
- R3: Bit 5 clears BUSY_OFF (default 60) edges after a write that found its fall timer idle. A write that arrives while that timer runs, including on the edge where it falls due, adds BUSY_OFF to the remaining count, and bit 5 stays set on that edge.
- R4: A write that finds the bit 4 rise timer idle arms it. Bit 4 sets PEND_ON (default 60) edges later. Writes that arrive while the rise timer runs do not change its expiry.
- R5: A write that finds the bit 4 fall timer idle arms it for PEND_ON+PEND_OFF (default 220) edges. A write that arrives while it runs adds PEND_OFF (default 160) to the remaining count. Bit 4 clears when this timer expires.
- R6: Bit 0 follows the rules of R4 and R5, with the delays DONE_ON (default 40) and DONE_OFF (default 100). Its rise comes 40 edges after an arming write and its fall 140 edges after it.
- R7: A remaining count never exceeds 2^CNT_W-1 (default 4095). An extension that would pass this value stops at it, so after a long burst of writes all three flags clear 4095 edges after the last write.
- R8: All status bits other than 5, 4 and 0 are always zero.
- R9: A read strobe sampled at an edge loads `rd_data_o` with the status value from just before that edge. Without a read strobe, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One bus write per clock edge where it is high |
| rd_stb | input | 1 | Capture the status word into `rd_data_o` |
| status_o | output | STAT_W | Live status word (bit 5 busy, bit 4 pending, bit 0 done) |
| rd_data_o | output | STAT_W | Status word captured by the last read strobe |

## Verification
The bench places a write on the exact edge where the busy fall timer is due. A design that let the timer fire there, or that restarted it instead of extending it, would show bit 5 dropping for a cycle or clearing too early. Back-to-back writes expose a design that restarts the fall timers, which would clear bits 4 and 0 after a single delay instead of the summed one, and also a design that re-arms a running rise timer, which would set those bits late. A burst of 80 writes overflows the 12-bit counters: a wrapping counter would clear the flags thousands of edges early, and a missing cap would leave them set too long. Random write and read traffic then compares every bit and the read register with an absolute-deadline model on every cycle.

// File: rtl/fst_pkg.sv
package fst_pkg;
   // Status bit positions decoded by the reading software
   localparam int BUSY_POS = 5;
   localparam int PEND_POS = 4;
   localparam int DONE_POS = 0;
   localparam int MIN_STAT_W = BUSY_POS + 1;
   localparam int NUM_PAIRS = 2;
endpackage

// File: rtl/fst_timer.sv
module fst_timer #(
   parameter int CNT_W  = 12,
   parameter int LOAD   = 60,
   parameter int ADD    = 60,
   parameter bit EXTEND = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic fire_o
);
   localparam int unsigned MAXV  = (32'd1 << CNT_W) - 32'd1;
   localparam int unsigned LOADV = (LOAD > MAXV) ? MAXV : LOAD;

   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_w
      $error("fst_timer: CNT_W out of range");
   end
   if (LOAD < 1) begin : g_bad_load
      $error("fst_timer: LOAD must be at least one");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             busy;

   assign busy = (cnt_q != '0);

   if (EXTEND) begin : g_ext
      int unsigned sum;
      always_comb begin
         sum = 32'(cnt_q) + ADD - 32'd1;
         if (start_i && busy)
            cnt_d = (sum > MAXV) ? CNT_W'(MAXV) : sum[CNT_W-1:0];
         else if (start_i)
            cnt_d = CNT_W'(LOADV);
         else if (busy)
            cnt_d = cnt_q - 1'b1;
         else
            cnt_d = cnt_q;
      end
      assign fire_o = busy && (cnt_q == CNT_W'(1)) && !start_i;
   end else begin : g_hold
      always_comb begin
         if (start_i && !busy)
            cnt_d = CNT_W'(LOADV);
         else if (busy)
            cnt_d = cnt_q - 1'b1;
         else
            cnt_d = cnt_q;
      end
      assign fire_o = busy && (cnt_q == CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end
endmodule

// File: rtl/fst_flag.sv
module fst_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // a set and a clear on the same edge: set applied first, clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= (q_o | set_i) & ~clr_i;
   end
endmodule

// File: rtl/busfifo_stat_timers.sv
module busfifo_stat_timers #(
   parameter int STAT_W   = 8,
   parameter int CNT_W    = 12,
   parameter int BUSY_OFF = 60,
   parameter int PEND_ON  = 60,
   parameter int PEND_OFF = 160,
   parameter int DONE_ON  = 40,
   parameter int DONE_OFF = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              rd_stb,
   output logic [STAT_W-1:0] status_o,
   output logic [STAT_W-1:0] rd_data_o
);
   import fst_pkg::*;

   if (STAT_W < MIN_STAT_W) begin : g_bad_stat
      $error("busfifo_stat_timers: STAT_W too narrow for the flag positions");
   end
   if (DONE_OFF < 0 || PEND_OFF < 0 || BUSY_OFF < 1) begin : g_bad_delay
      $error("busfifo_stat_timers: illegal delay parameter");
   end

   logic busy_fire, busy_q;
   logic [NUM_PAIRS-1:0] pair_q;

   fst_timer #(.CNT_W(CNT_W), .LOAD(BUSY_OFF), .ADD(BUSY_OFF), .EXTEND(1'b1)) u_busy_off (
      .clk(clk), .rst_n(rst_n), .start_i(wr_stb), .fire_o(busy_fire));

   fst_flag u_busy_flag (
      .clk(clk), .rst_n(rst_n), .set_i(wr_stb), .clr_i(busy_fire), .q_o(busy_q));

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      localparam int D_ON  = (k == 0) ? PEND_ON  : DONE_ON;
      localparam int D_OFF = (k == 0) ? PEND_OFF : DONE_OFF;
      logic on_fire, off_fire;

      fst_timer #(.CNT_W(CNT_W), .LOAD(D_ON), .ADD(D_ON), .EXTEND(1'b0)) u_on (
         .clk(clk), .rst_n(rst_n), .start_i(wr_stb), .fire_o(on_fire));

      fst_timer #(.CNT_W(CNT_W), .LOAD(D_ON + D_OFF), .ADD(D_OFF), .EXTEND(1'b1)) u_off (
         .clk(clk), .rst_n(rst_n), .start_i(wr_stb), .fire_o(off_fire));

      fst_flag u_flag (
         .clk(clk), .rst_n(rst_n), .set_i(on_fire), .clr_i(off_fire), .q_o(pair_q[k]));
   end

   always_comb begin
      status_o           = '0;
      status_o[BUSY_POS] = busy_q;
      status_o[PEND_POS] = pair_q[0];
      status_o[DONE_POS] = pair_q[1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_data_o <= '0;
      else if (rd_stb) rd_data_o <= status_o;
   end
endmodule

// File: rtl/busfifo_stat_chk.sv
module busfifo_stat_chk #(
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [STAT_W-1:0] status,
   input logic [STAT_W-1:0] rd_data
);
   import fst_pkg::*;
   localparam logic [STAT_W-1:0] USED =
      (STAT_W'(1) << BUSY_POS) | (STAT_W'(1) << PEND_POS) | (STAT_W'(1) << DONE_POS);

   p_wr_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> status[BUSY_POS]);

   p_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[BUSY_POS]) |-> !$past(wr_stb));

   p_spare_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~USED) == '0);

   p_rd_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_data == $past(status));

   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));
endmodule

bind busfifo_stat_timers busfifo_stat_chk #(.STAT_W(STAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
   .status(status_o), .rd_data(rd_data_o));

// File: tb/test_busfifo_stat_timers.sv
module test_busfifo_stat_timers;
   localparam int     STAT_W = 8;
   localparam longint MAXV   = 4095;
   localparam longint B_OFF  = 60;
   localparam longint P_ON   = 60;
   localparam longint P_OFF  = 160;
   localparam longint D_ON   = 40;
   localparam longint D_OFF  = 100;

   logic clk = 1'b0;
   logic rst_n, wr_stb, rd_stb;
   logic [STAT_W-1:0] status_o, rd_data_o;

   always #10 clk = ~clk;

   busfifo_stat_timers i_busfifo_stat_timers (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .status_o(status_o), .rd_data_o(rd_data_o));

   int n_run = 0, n_fail = 0;
   bit done = 1'b0, any_wr = 1'b0, sat_phase = 1'b0;
   longint t;
   longint dl_b, dl_pn, dl_pf, dl_dn, dl_df;
   logic [STAT_W-1:0] m_st, m_rd;

   function automatic longint cap(longint v, longint lim);
      return (v < lim) ? v : lim;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s edge %0d: actual %0h expected %0h", req, t, act, exp);
      end
   endtask

   task automatic pair(bit w, longint don, longint doff,
                       inout longint dn, inout longint df, output bit s, output bit c);
      s = 1'b0; c = 1'b0;
      if (dn == t) begin s = 1'b1; dn = -1; end
      else if (w && dn < 0) dn = t + cap(don, MAXV);
      if (w) df = (df >= t) ? cap(df + doff, t + MAXV) : t + cap(don + doff, MAXV);
      else if (df == t) begin c = 1'b1; df = -1; end
   endtask

   task automatic model_step(bit w, bit r);
      bit sb, cb, sp, cp, sd, cd;
      t++;
      if (r) m_rd = m_st;
      sb = 1'b0; cb = 1'b0;
      if (w) begin
         sb = 1'b1;
         dl_b = (dl_b >= t) ? cap(dl_b + B_OFF, t + MAXV) : t + cap(B_OFF, MAXV);
      end else if (dl_b == t) begin
         cb = 1'b1; dl_b = -1;
      end
      pair(w, P_ON, P_OFF, dl_pn, dl_pf, sp, cp);
      pair(w, D_ON, D_OFF, dl_dn, dl_df, sd, cd);
      m_st[5] = (m_st[5] | sb) & ~cb;
      m_st[4] = (m_st[4] | sp) & ~cp;
      m_st[0] = (m_st[0] | sd) & ~cd;
   endtask

   task automatic cycle(bit w, bit r);
      wr_stb = w; rd_stb = r;
      @(posedge clk);
      model_step(w, r);
      if (w) any_wr = 1'b1;
      @(negedge clk);
      if (!any_wr) begin
         chk("R1", status_o, 0);
      end else if (sat_phase) begin
         chk("R7", status_o[5], m_st[5]);
         chk("R7", status_o[4], m_st[4]);
         chk("R7", status_o[0], m_st[0]);
      end else begin
         if (w) chk("R2", status_o[5], m_st[5]);
         else   chk("R3", status_o[5], m_st[5]);
         if (m_st[4]) chk("R4", status_o[4], m_st[4]);
         else         chk("R5", status_o[4], m_st[4]);
         chk("R6", status_o[0], m_st[0]);
      end
      chk("R8", status_o & 8'b1100_1110, 0);
      chk("R9", rd_data_o, m_rd);
   endtask

   initial begin
      rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
      t = 0; dl_b = -1; dl_pn = -1; dl_pf = -1; dl_dn = -1; dl_df = -1;
      m_st = '0; m_rd = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", status_o, 0);
      chk("R1", rd_data_o, 0);
      rst_n = 1'b1;
      repeat (20) cycle(1'b0, 1'b1);
      // single write: busy 60, pending 60..220, done 40..140
      cycle(1'b1, 1'b0);
      for (int i = 0; i < 300; i++) cycle(1'b0, (i % 7) == 0);
      // write exactly on the edge the busy fall timer is due
      cycle(1'b1, 1'b0);
      repeat (59) cycle(1'b0, 1'b0);
      cycle(1'b1, 1'b1);
      repeat (400) cycle(1'b0, 1'b0);
      // back-to-back writes: fall timers extend, rise timers hold
      repeat (3) cycle(1'b1, 1'b0);
      repeat (800) cycle(1'b0, 1'b1);
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 200) == 0) repeat (5) cycle(1'b1, 1'b0);
         else cycle(($urandom % 40) == 0, ($urandom % 4) == 0);
      end
      repeat (4200) cycle(1'b0, 1'b0);
      // saturation: long burst overflows every counter
      sat_phase = 1'b1;
      repeat (80) cycle(1'b1, 1'b1);
      repeat (4200) cycle(1'b0, ($urandom % 8) == 0);
      chk("R7", status_o, 0);
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule